// File: doc/BRIEF.md
# Compressed-Audio Burst Sync Detector

This block sits behind a receiver's subframe decoder and inspects the 16-bit data words pulled out of each received subframe. It searches the accepted word stream for the 96-bit burst sync used to mark compressed (non-linear PCM) audio in a stereo stream. The sync is four zero words followed by 0xF872 and then 0x4E1F. When the whole sequence has been seen, the block raises a "compressed stream present" flag. It then captures the two burst preamble words that follow the sync, the burst-info word and then the length word, into output registers.

The flag is held while syncs keep arriving. A separate frame-boundary strobe drives a frame counter. If 4096 frames pass without a new sync, the flag drops. The captured preamble words keep their values after the flag drops, and they change only when a new sync is followed by new preamble words.

Words enter over a valid/ready interface. The block never applies back-pressure: `in_ready` stays high at all times, including during reset. A word is consumed on every clock edge where `in_valid` is high. Cycles with `in_valid` low are skipped entirely. The frame strobe is a plain control input and is not handshaken.

Top module: `burst_sync_detect`

## Requirements
- R1: A synchronous active-high reset clears the flag, both preamble registers and the frame counter. After reset, `comp_active` reads 0, and `burst_info` and `burst_len` read 0x0000.
- R2: `in_ready` is 1 on every cycle. A word is accepted only when `in_valid` is 1. Cycles with `in_valid` low neither advance nor break a partial sync match.
- R3: Six consecutively accepted words 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F set `comp_active` to 1 from the clock edge that accepts the 0x4E1F word.
- R4: An accepted word that neither continues the sequence nor is 0x0000 discards the partial match. In that case, a later sync must be complete on its own to be detected.
- R5: Zero words keep a partial match alive. More than four leading zeros still leave a four-zero run ready for 0xF872. A zero received where 0x4E1F was expected starts a fresh run that holds that one zero.
- R6: The first accepted word after a detected sync is loaded into `burst_info`, and the second into `burst_len`. Each value is visible after the edge that accepts its word.
- R7: `burst_info` and `burst_len` change only through the capture in R6. Non-sync traffic and the flag dropping leave them unchanged.
- R8: While `comp_active` is 1, each cycle with `frame_tick` high counts one frame. The flag returns to 0 on the edge of the 4096th counted frame after the most recent sync. The 4095th frame leaves it at 1.
- R9: Every detected sync restarts the frame count from zero. If a sync and a frame strobe occur on the same edge, the sync wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Subframe data word present |
| in_ready | output | 1 | Always 1, the block never stalls |
| in_data | input | 16 | Subframe data word |
| frame_tick | input | 1 | One-cycle strobe per received frame |
| comp_active | output | 1 | Compressed-stream flag |
| burst_info | output | 16 | First preamble word after the last sync |
| burst_len | output | 16 | Second preamble word after the last sync |

## Verification
The bench feeds the following runs, each with a wrong design's symptom:
- More than four leading zeros, and a zero standing where 0x4E1F belongs. A matcher that restarts to an empty state on every mismatch misses these syncs and leaves the flag low.
- Sync words separated by idle cycles that carry non-matching data. A design that looks at `in_data` without qualifying it by `in_valid` loses the match.
- 4095 and 4096 frame strobes after a sync, and a second sync in the middle of the window. An off-by-one counter drops the flag one frame early or late, and a missing reload drops the flag too soon.
- Preamble registers read after non-sync traffic and after a timeout. A design that reloads them on any word, or clears them with the flag, reports the wrong values.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int WORD_W   = 16;
  localparam int SYNC_LEN = 6;
  localparam int ZERO_RUN = 4;
  localparam int IDX_W    = $clog2(SYNC_LEN);

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_INFO = 2'd1,
    CAP_LEN  = 2'd2
  } cap_state_t;

  function automatic logic [WORD_W-1:0] sync_word(input logic [IDX_W-1:0] idx);
    logic [WORD_W-1:0] w;
    if (int'(idx) < ZERO_RUN)      w = '0;
    else if (int'(idx) == ZERO_RUN) w = 16'hF872;
    else                            w = 16'h4E1F;
    return w;
  endfunction
endpackage

// File: rtl/bsd_matcher.sv
module bsd_matcher
  import bsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output logic [IDX_W-1:0]  idx_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYNC_LEN - 1);
  localparam logic [IDX_W-1:0] RUN_IDX  = IDX_W'(ZERO_RUN);

  logic [IDX_W-1:0] idx_d;
  logic             expect_ok;
  logic             is_zero;

  always_comb begin
    expect_ok = (word == sync_word(idx_q));
    is_zero   = (word == '0);
    hit       = take && expect_ok && (idx_q == LAST_IDX);
    idx_d     = idx_q;
    if (take) begin
      if (expect_ok) begin
        idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end else if (is_zero) begin
        // longest zero suffix that is still a prefix of the sync
        idx_d = (idx_q == RUN_IDX) ? RUN_IDX : IDX_W'(1);
      end else begin
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_d;
  end
endmodule

// File: rtl/bsd_capture.sv
module bsd_capture
  import bsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              hit,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] info_q,
  output logic [WORD_W-1:0] len_q
);
  cap_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (hit) begin
      st_d = CAP_INFO;
    end else if (take) begin
      unique case (st_q)
        CAP_INFO: st_d = CAP_LEN;
        CAP_LEN:  st_d = CAP_IDLE;
        default:  st_d = CAP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CAP_IDLE;
      info_q <= '0;
      len_q  <= '0;
    end else begin
      st_q <= st_d;
      if (take && !hit && st_q == CAP_INFO) info_q <= word;
      if (take && !hit && st_q == CAP_LEN)  len_q  <= word;
    end
  end
endmodule

// File: rtl/bsd_hold_timer.sv
module bsd_hold_timer #(
  parameter int TIMEOUT_FRAMES = 4096,
  localparam int CNT_W = (TIMEOUT_FRAMES > 1) ? $clog2(TIMEOUT_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             tick,
  output logic             flag_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_FRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (hit) begin
      flag_q <= 1'b1;
      cnt_q  <= '0;
    end else if (flag_q && tick) begin
      if (cnt_q == LAST) begin
        flag_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_sync_detect.sv
module burst_sync_detect
  import bsd_pkg::*;
#(
  parameter int TIMEOUT_FRAMES = 4096,
  localparam int CNT_W = (TIMEOUT_FRAMES > 1) ? $clog2(TIMEOUT_FRAMES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              frame_tick,
  output logic              comp_active,
  output logic [WORD_W-1:0] burst_info,
  output logic [WORD_W-1:0] burst_len
);
  logic             take;
  logic             sync_hit;
  logic [IDX_W-1:0] match_idx;
  logic [CNT_W-1:0] hold_count;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  bsd_matcher u_match (
    .clk  (clk),
    .rst  (rst),
    .take (take),
    .word (in_data),
    .hit  (sync_hit),
    .idx_q(match_idx)
  );

  bsd_capture u_cap (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .hit   (sync_hit),
    .word  (in_data),
    .info_q(burst_info),
    .len_q (burst_len)
  );

  bsd_hold_timer #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .hit   (sync_hit),
    .tick  (frame_tick),
    .flag_q(comp_active),
    .cnt_q (hold_count)
  );
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker
  import bsd_pkg::*;
#(
  parameter int TIMEOUT_FRAMES = 4096,
  localparam int CNT_W = (TIMEOUT_FRAMES > 1) ? $clog2(TIMEOUT_FRAMES) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              frame_tick,
  input logic              comp_active,
  input logic [WORD_W-1:0] burst_info,
  input logic [WORD_W-1:0] burst_len,
  input logic              sync_hit,
  input logic [IDX_W-1:0]  match_idx,
  input logic [CNT_W-1:0]  hold_count
);
  a_r2_always_ready: assert property (@(posedge clk) in_ready);

  a_r2_idle_holds_match: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(match_idx));

  a_r3_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
    sync_hit |=> comp_active);

  a_r8_drop_needs_tick: assert property (@(posedge clk) disable iff (rst)
    ($fell(comp_active) && !$past(rst)) |-> $past(frame_tick));

  a_r9_hit_reloads: assert property (@(posedge clk) disable iff (rst)
    sync_hit |=> (hold_count == '0));

  a_r7_info_needs_word: assert property (@(posedge clk) disable iff (rst)
    (!$stable(burst_info) && !$past(rst)) |-> $past(in_valid));

  a_r7_len_needs_word: assert property (@(posedge clk) disable iff (rst)
    (!$stable(burst_len) && !$past(rst)) |-> $past(in_valid));

  a_r5_index_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(match_idx) < SYNC_LEN);
endmodule

bind burst_sync_detect bsd_checker #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .frame_tick (frame_tick),
  .comp_active(comp_active),
  .burst_info (burst_info),
  .burst_len  (burst_len),
  .sync_hit   (sync_hit),
  .match_idx  (match_idx),
  .hold_count (hold_count)
);

// File: tb/tb_burst_sync_detect.sv
`timescale 1ns/1ps
module tb_burst_sync_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = 16'h0;
  logic        frame_tick = 1'b0;
  logic        comp_active;
  logic [15:0] burst_info, burst_len;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  burst_sync_detect dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .frame_tick(frame_tick), .comp_active(comp_active),
    .burst_info(burst_info), .burst_len(burst_len)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0; frame_tick = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk); in_valid = 1'b1; in_data = w;
    @(negedge clk); in_valid = 1'b0; in_data = 16'hFFFF;
  endtask

  task automatic send_sync();
    for (int i = 0; i < 4; i++) send(16'h0000);
    send(16'hF872); send(16'h4E1F);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); frame_tick = 1'b1;
    repeat (n) @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 flag after reset", comp_active, 0);
    check("R1 info after reset", burst_info, 0);
    check("R1 len after reset", burst_len, 0);
    check("R2 ready during idle", in_ready, 1);
  endtask

  task automatic t_basic();
    do_reset();
    for (int i = 0; i < 4; i++) send(16'h0000);
    send(16'hF872);
    check("R3 flag low before last word", comp_active, 0);
    send(16'h4E1F);
    check("R3 flag after full sync", comp_active, 1);
    send(16'h0103);
    check("R6 info captured", burst_info, 16'h0103);
    check("R6 len not yet", burst_len, 16'h0000);
    send(16'h1800);
    check("R6 len captured", burst_len, 16'h1800);
    send(16'h5555); send(16'h6666);
    check("R7 info kept after traffic", burst_info, 16'h0103);
    check("R7 len kept after traffic", burst_len, 16'h1800);
  endtask

  task automatic t_mismatch();
    do_reset();
    for (int i = 0; i < 4; i++) send(16'h0000);
    send(16'hF872); send(16'h1234); send(16'h4E1F);
    check("R4 broken sync ignored", comp_active, 0);
    send(16'h0000); send(16'h0000); send(16'h0000); send(16'h0007);
    send(16'hF872); send(16'h4E1F);
    check("R4 short zero run ignored", comp_active, 0);
    send(16'hAAAA); send(16'hBBBB);
    check("R7 no capture without sync", burst_info, 16'h0000);
  endtask

  task automatic t_zero_overlap();
    do_reset();
    for (int i = 0; i < 7; i++) send(16'h0000);
    send(16'hF872); send(16'h4E1F);
    check("R5 extra leading zeros", comp_active, 1);
    do_reset();
    for (int i = 0; i < 4; i++) send(16'h0000);
    send(16'hF872); send(16'h0000);
    send(16'h0000); send(16'h0000); send(16'h0000);
    send(16'hF872); send(16'h4E1F);
    check("R5 zero in place of last word restarts run", comp_active, 1);
  endtask

  task automatic t_gaps();
    do_reset();
    for (int i = 0; i < 6; i++) begin
      logic [15:0] w;
      w = (i < 4) ? 16'h0000 : (i == 4) ? 16'hF872 : 16'h4E1F;
      send(w);
      @(negedge clk); in_data = 16'h9999;
      @(negedge clk);
    end
    check("R2 idle cycles do not break match", comp_active, 1);
  endtask

  task automatic t_timeout();
    do_reset();
    send_sync(); send(16'h0001); send(16'h0002);
    ticks(4095);
    check("R8 flag held at 4095 frames", comp_active, 1);
    ticks(1);
    check("R8 flag drops at 4096 frames", comp_active, 0);
    check("R7 info kept after drop", burst_info, 16'h0001);
    check("R7 len kept after drop", burst_len, 16'h0002);
    ticks(10);
    check("R8 ticks while low do nothing", comp_active, 0);
  endtask

  task automatic t_reload();
    do_reset();
    send_sync();
    ticks(3000);
    send_sync();
    ticks(3000);
    check("R9 resync reloads count", comp_active, 1);
    ticks(1095);
    check("R9 held until 4096 after resync", comp_active, 1);
    ticks(1);
    check("R9 drop at 4096 after resync", comp_active, 0);
    // sync and tick on the same edge
    send_sync();
    ticks(4000);
    for (int i = 0; i < 4; i++) send(16'h0000);
    send(16'hF872);
    @(negedge clk); in_valid = 1'b1; in_data = 16'h4E1F; frame_tick = 1'b1;
    @(negedge clk); in_valid = 1'b0; frame_tick = 1'b0;
    ticks(4095);
    check("R9 sync wins over same-edge tick", comp_active, 1);
    ticks(1);
    check("R9 drop after same-edge case", comp_active, 0);
  endtask

  task automatic t_mid_reset();
    do_reset();
    send_sync(); send(16'h00AA); send(16'h00BB);
    do_reset();
    check("R1 reset clears flag", comp_active, 0);
    check("R1 reset clears info", burst_info, 0);
    check("R1 reset clears len", burst_len, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_mismatch();
    t_zero_overlap();
    t_gaps();
    t_timeout();
    t_reload();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule